// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block turns the control pins of a synchronous burst SRAM into one decision per clock. It takes the chip enables, two address strobes, the burst-advance input and a write request, and reports the cycle type. The cycle types are idle, read start, read continue, read hold and write. It also reports where the address for this cycle comes from, whether the burst counter steps, and whether the data pins may be driven. The two strobes are qualified differently. The processor-side strobe only counts while the first enable is low. The controller-side strobe counts regardless, but yields an idle cycle when the device is not fully selected.

An asynchronous sleep input is brought into the clock domain through two flops. While the device sleeps, every cycle is forced idle. On leaving sleep, a fixed recovery window keeps the decoder idle. A violation flag reports any enable or strobe that is active during that window. The output enable for the data bus follows the bus output-enable pin without a register, so it can turn the bus off between clock edges.

Top module: `sbsram_cycle_ctrl`

## Requirements
- R1: An access that starts at the external address needs full selection: `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. Any other combination gives idle (`cycle_o`=0, `addr_sel_o`=0).
- R2: With `ce1_ni`=1 the processor strobe `adsp_ni` has no effect. If `adsc_ni`=0 as well, the cycle is idle. If `adsc_ni`=1, the cycle is decoded from `adv_ni` as in R5/R6.
- R3: `adsp_ni`=0 while fully selected gives a read start (`cycle_o`=1) from the external address (`addr_sel_o`=1), even when `wr_req_i`=1.
- R4: `adsc_ni`=0 with `adsp_ni`=1 while fully selected starts at the external address. The cycle is a read start (1), or a write (`cycle_o`=4) when `wr_req_i`=1. If `ce2_i` or `ce3_ni` is inactive, the cycle is idle.
- R5: With both strobes high and `adv_ni`=0, the address comes from the next burst address (`addr_sel_o`=2) and `burst_adv_o`=1. The cycle is read continue (2), or write (4) when requested. The enables have no effect.
- R6: With both strobes high and `adv_ni`=1, the current address is reused (`addr_sel_o`=3) and `burst_adv_o`=0. The cycle is read hold (3), or write (4) when requested.
- R7: `dq_oe_o` is 1 only in read cycle types (1, 2, 3) with `oe_ni`=0. It follows `oe_ni` without waiting for a clock edge.
- R8: `sleep_o` rises on the second rising edge after `zz_i` goes high and falls on the second rising edge after it goes low. While `sleep_o`=1, every cycle is idle and `dq_oe_o`=0.
- R9: After `sleep_o` falls, `recover_o`=1 for exactly 2 cycles (parameter `REC_CYC`), and cycles stay idle.
- R10: `proto_err_o`=1 exactly when `recover_o`=1 and any of these holds: `ce1_ni`=0, `ce2_i`=1, `ce3_ni`=0, `adsp_ni`=0, `adsc_ni`=0.
- R11: During reset, `sleep_o`, `recover_o` and `proto_err_o` are 0 even with `zz_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce1_ni | input | 1 | First chip enable, active low |
| ce2_i | input | 1 | Second chip enable, active high |
| ce3_ni | input | 1 | Third chip enable, active low |
| adsp_ni | input | 1 | Processor-side address strobe, active low |
| adsc_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| wr_req_i | input | 1 | Write requested this cycle |
| oe_ni | input | 1 | Asynchronous data output enable, active low |
| zz_i | input | 1 | Asynchronous sleep request |
| cycle_o | output | 3 | Cycle type: 0 idle, 1 read start, 2 read continue, 3 read hold, 4 write |
| addr_sel_o | output | 2 | Address source: 0 none, 1 external, 2 next, 3 current |
| burst_adv_o | output | 1 | Step the burst counter |
| sleep_o | output | 1 | Synchronised sleep state |
| recover_o | output | 1 | Recovery window after sleep exit |
| dq_oe_o | output | 1 | Drive enable for the data bus |
| proto_err_o | output | 1 | Enable or strobe active during recovery |

## Verification
The assertions assume that `zz_i` is steady at each sampling edge, so the two-flop chain delays it by exactly two samples, and that reset starts with the sleep chain clear. The bench changes every input, `zz_i` included, on the falling clock edge. It compares the combinational decode results shortly after each change, and samples the registered sleep and recovery outputs only on falling edges that follow the rising edge of interest. The output-enable check toggles `oe_ni` between edges on purpose, to show that the bus gate reacts without a clock.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_RD_START = 3'd1,
    CYC_RD_CONT  = 3'd2,
    CYC_RD_HOLD  = 3'd3,
    CYC_WRITE    = 3'd4
  } cycle_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_NEXT = 2'd2,
    SRC_CUR  = 2'd3
  } addr_src_e;

  function automatic logic is_read(cycle_e c);
    return (c == CYC_RD_START) || (c == CYC_RD_CONT) || (c == CYC_RD_HOLD);
  endfunction

endpackage

// File: rtl/sbsram_sleep_ctl.sv
module sbsram_sleep_ctl #(
  parameter int REC_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zz_i,
  output logic sleep_o,
  output logic recover_o
);
  localparam int CNT_W = $clog2(REC_CYC + 1);

  logic             meta_q, sync_q;
  logic [CNT_W-1:0] rec_q, rec_d;
  logic             exit_now;

  // two-flop synchroniser for the asynchronous sleep request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= zz_i;
      sync_q <= meta_q;
    end
  end

  assign exit_now = sync_q & ~meta_q;

  always_comb begin
    rec_d = rec_q;
    if (exit_now)
      rec_d = CNT_W'(REC_CYC);
    else if (rec_q != '0)
      rec_d = rec_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rec_q <= '0;
    else         rec_q <= rec_d;
  end

  assign sleep_o   = sync_q;
  assign recover_o = (rec_q != '0);

  p_sleep_lag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(zz_i, 2));

  p_wake_lag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> !$past(zz_i, 2));

  p_recover_follows_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> recover_o);

  p_no_recover_asleep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !recover_o);

endmodule

// File: rtl/sbsram_cycle_dec.sv
module sbsram_cycle_dec
  import sbsram_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      block_i,
  input  logic      ce1_ni,
  input  logic      ce2_i,
  input  logic      ce3_ni,
  input  logic      adsp_ni,
  input  logic      adsc_ni,
  input  logic      adv_ni,
  input  logic      wr_req_i,
  output cycle_e    cycle_o,
  output addr_src_e src_o,
  output logic      cnt_en_o
);
  logic selected;
  logic adsp_live;

  assign selected  = ~ce1_ni & ce2_i & ~ce3_ni;
  // processor strobe only counts while the first enable is active
  assign adsp_live = ~adsp_ni & ~ce1_ni;

  always_comb begin
    cycle_o  = CYC_IDLE;
    src_o    = SRC_NONE;
    cnt_en_o = 1'b0;
    if (block_i) begin
      cycle_o = CYC_IDLE;
    end else if (adsp_live) begin
      if (selected) begin
        cycle_o = CYC_RD_START;
        src_o   = SRC_EXT;
      end
    end else if (!adsc_ni) begin
      if (selected) begin
        cycle_o = wr_req_i ? CYC_WRITE : CYC_RD_START;
        src_o   = SRC_EXT;
      end
    end else if (!adv_ni) begin
      cycle_o  = wr_req_i ? CYC_WRITE : CYC_RD_CONT;
      src_o    = SRC_NEXT;
      cnt_en_o = 1'b1;
    end else begin
      cycle_o = wr_req_i ? CYC_WRITE : CYC_RD_HOLD;
      src_o   = SRC_CUR;
    end
  end

  p_ext_needs_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o == SRC_EXT) |-> (!ce1_ni && ce2_i && !ce3_ni));

  p_adsp_reads_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!block_i && !adsp_ni && !ce1_ni && ce2_i && !ce3_ni) |-> (cycle_o == CYC_RD_START));

  p_step_on_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_o |-> (src_o == SRC_NEXT && adsc_ni && !adv_ni));

  p_hold_keeps_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o == CYC_RD_HOLD) |-> (src_o == SRC_CUR && adv_ni && !cnt_en_o));

endmodule

// File: rtl/sbsram_cycle_ctrl.sv
module sbsram_cycle_ctrl
  import sbsram_pkg::*;
#(
  parameter int REC_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce1_ni,
  input  logic       ce2_i,
  input  logic       ce3_ni,
  input  logic       adsp_ni,
  input  logic       adsc_ni,
  input  logic       adv_ni,
  input  logic       wr_req_i,
  input  logic       oe_ni,
  input  logic       zz_i,
  output logic [2:0] cycle_o,
  output logic [1:0] addr_sel_o,
  output logic       burst_adv_o,
  output logic       sleep_o,
  output logic       recover_o,
  output logic       dq_oe_o,
  output logic       proto_err_o
);
  cycle_e    cyc;
  addr_src_e src;
  logic      cnt_en;
  logic      asleep, recov, blocked, any_active;

  sbsram_sleep_ctl #(.REC_CYC(REC_CYC)) u_sleep (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .zz_i      (zz_i),
    .sleep_o   (asleep),
    .recover_o (recov)
  );

  assign blocked = asleep | recov;

  sbsram_cycle_dec u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .block_i  (blocked),
    .ce1_ni   (ce1_ni),
    .ce2_i    (ce2_i),
    .ce3_ni   (ce3_ni),
    .adsp_ni  (adsp_ni),
    .adsc_ni  (adsc_ni),
    .adv_ni   (adv_ni),
    .wr_req_i (wr_req_i),
    .cycle_o  (cyc),
    .src_o    (src),
    .cnt_en_o (cnt_en)
  );

  assign any_active = ~ce1_ni | ce2_i | ~ce3_ni | ~adsp_ni | ~adsc_ni;

  assign cycle_o     = cyc;
  assign addr_sel_o  = src;
  assign burst_adv_o = cnt_en;
  assign sleep_o     = asleep;
  assign recover_o   = recov;
  // output enable is not registered: the bus gate follows oe_ni at once
  assign dq_oe_o     = is_read(cyc) & ~oe_ni;
  assign proto_err_o = recov & any_active;

  p_block_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o || recover_o) |-> (cycle_o == 3'd0 && !burst_adv_o && !dq_oe_o));

  p_dq_float_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || cycle_o == 3'd0 || cycle_o == 3'd4) |-> !dq_oe_o);

  p_err_in_window_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> recover_o);

endmodule

// File: tb/sbsram_cycle_ctrl_test.sv
`timescale 1ns/100ps
module sbsram_cycle_ctrl_test;

  logic clk = 1'b0;
  logic rst_n;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, wr, oe_n, zz;
  logic [2:0] cyc;
  logic [1:0] asel;
  logic badv, slp, rec, dqoe, perr;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sbsram_cycle_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n),
    .wr_req_i(wr), .oe_ni(oe_n), .zz_i(zz),
    .cycle_o(cyc), .addr_sel_o(asel), .burst_adv_o(badv),
    .sleep_o(slp), .recover_o(rec), .dq_oe_o(dqoe), .proto_err_o(perr)
  );

  // inputs {ce1_n,ce2,ce3_n,adsp_n,adsc_n,adv_n,wr,oe_n}, expected {cycle,src,adv,dq}
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {8'b0100_1100, 3'd1, 2'd1, 1'b0, 1'b1},  // R3 read start
    {8'b0100_1110, 3'd1, 2'd1, 1'b0, 1'b1},  // R3 write request ignored
    {8'b1100_0100, 3'd0, 2'd0, 1'b0, 1'b0},  // R2 ce1 high, adsc low
    {8'b1100_1000, 3'd2, 2'd2, 1'b1, 1'b1},  // R2 adsp ignored, continues
    {8'b0000_1100, 3'd0, 2'd0, 1'b0, 1'b0},  // R1 ce2 low
    {8'b0110_1100, 3'd0, 2'd0, 1'b0, 1'b0},  // R1 ce3 high
    {8'b0101_0100, 3'd1, 2'd1, 1'b0, 1'b1},  // R4 read via adsc
    {8'b0101_0110, 3'd4, 2'd1, 1'b0, 1'b0},  // R4 write via adsc
    {8'b0111_0100, 3'd0, 2'd0, 1'b0, 1'b0},  // R4 ce3 inactive
    {8'b1011_1000, 3'd2, 2'd2, 1'b1, 1'b1},  // R5 enables ignored
    {8'b0101_1001, 3'd2, 2'd2, 1'b1, 1'b0},  // R7 oe high
    {8'b1011_1100, 3'd3, 2'd3, 1'b0, 1'b1},  // R6 read hold
    {8'b1011_1110, 3'd4, 2'd3, 1'b0, 1'b0},  // R6 write at current
    {8'b0101_1101, 3'd3, 2'd3, 1'b0, 1'b0},  // R7 hold with oe high
    {8'b0100_1101, 3'd1, 2'd1, 1'b0, 1'b0}   // R7 start with oe high
  };

  function automatic string vtag(int i);
    case (i)
      0, 1:          return "R3";
      2, 3:          return "R2";
      4, 5:          return "R1";
      6, 7, 8:       return "R4";
      9:             return "R5";
      11, 12:        return "R6";
      default:       return "R7";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(logic [7:0] v);
    {ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, wr, oe_n} = v;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    zz    = 1'b1;
    drive(8'b1100_0100);
    repeat (4) tick();
    // R11 reset state
    check("R11 sleep", int'(slp), 0);
    check("R11 recover", int'(rec), 0);
    check("R11 err", int'(perr), 0);
    zz = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (3) tick();

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14:7]);
      #1;
      check({vtag(i), " cycle"}, int'(cyc),  int'(VEC[i][6:4]));
      check({vtag(i), " src"},   int'(asel), int'(VEC[i][3:2]));
      check({vtag(i), " adv"},   int'(badv), int'(VEC[i][1]));
      check({vtag(i), " dq"},    int'(dqoe), int'(VEC[i][0]));
      tick();
    end

    // R7 asynchronous output enable between edges
    drive(8'b0100_1100);
    #1 check("R7 dq on", int'(dqoe), 1);
    oe_n = 1'b1;
    #0.5 check("R7 dq off async", int'(dqoe), 0);
    oe_n = 1'b0;
    #0.5 check("R7 dq back", int'(dqoe), 1);
    tick();

    // R8 sleep entry takes two edges
    drive(8'b0100_1100);
    zz = 1'b1;
    tick();
    check("R8 not yet asleep", int'(slp), 0);
    check("R8 still decoding", int'(cyc), 1);
    tick();
    check("R8 asleep", int'(slp), 1);
    check("R8 forced idle", int'(cyc), 0);
    check("R8 bus off", int'(dqoe), 0);

    // R8/R9 exit and recovery
    drive(8'b1011_1100);
    zz = 1'b0;
    tick();
    check("R8 still asleep", int'(slp), 1);
    tick();
    check("R8 awake", int'(slp), 0);
    check("R9 recover 1", int'(rec), 1);
    check("R9 idle in window", int'(cyc), 0);
    check("R10 quiet inputs", int'(perr), 0);
    adsc_n = 1'b0;
    #1 check("R10 strobe in window", int'(perr), 1);
    adsc_n = 1'b1;
    ce2 = 1'b1;
    #1 check("R10 enable in window", int'(perr), 1);
    ce2 = 1'b0;
    tick();
    check("R9 recover 2", int'(rec), 1);
    check("R10 quiet again", int'(perr), 0);
    tick();
    check("R9 window over", int'(rec), 0);
    check("R9 decode resumes", int'(cyc), 3);
    adsc_n = 1'b0;
    #1 check("R10 outside window", int'(perr), 0);
    tick();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule